// File: doc/BRIEF.md
# GPIO Pad Output Mode Control

This block sits between the GPIO configuration state and the pad cells of a bank of pins. For each pin a 4-bit mode code selects whether the pin is a plain input, a software-driven output, a peripheral-driven output or an analog pin. The block turns that code into the N-side sink enable, the P-side source enable and the pull-up and pull-down enables that the pad cell needs. Drive type is chosen separately from data source, so both the output register and a peripheral can drive either push-pull or open-drain.

The block also holds the software output latch and returns two separate readback values. One is the latch itself. The other is the pad level after a two-flop synchronizer. Because these are separate, the two values can differ. The pad receiver stays connected while the pin drives, so a pin can read back what it is driving. In analog mode the digital input seen by the logic is held at 1.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: When `out_wr_en_i` is high at a rising clock edge, `out_rd_o` takes `out_wr_data_i` from that edge onward. Otherwise it holds its value. The mode and the pad level never affect it.
- R2: In open-drain modes (code 2 = output open-drain, code 4 = alternate open-drain), `drv_p_o` is 0. `drv_n_o` is the inverse of the pin's data bit, so data 1 leaves the pad undriven.
- R3: In push-pull modes (code 1 = output push-pull, code 3 = alternate push-pull), data 0 gives `drv_n_o`=1 and `drv_p_o`=0. Data 1 gives `drv_n_o`=0 and `drv_p_o`=1.
- R4: Codes 1 and 2 take the pin's data bit from the output latch (`out_rd_o`). Codes 3 and 4 take it from `alt_data_i`, and the latch has no effect on the drivers.
- R5: In alternate modes (codes 3, 4) and in analog mode (code 5), `pull_up_o` and `pull_dn_o` are both 0. In every other code, `pull_up_o` = `pull_en_i & pull_up_sel_i` and `pull_dn_o` = `pull_en_i & ~pull_up_sel_i`.
- R6: In analog mode (code 5), `in_rd_o` for that pin is 1 and both drivers are off.
- R7: In every mode other than analog, `in_rd_o` shows the `pad_in_i` level sampled two rising edges earlier. This includes the driving modes.
- R8: Input mode (code 0) and the unused codes 6 to 15 turn both drivers off.
- R9: While `rst_ni` is low, the output latch and both synchronizer stages are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4*NUM_PINS | Per-pin mode code; pin k uses bits [4k+3:4k] |
| out_wr_en_i | input | 1 | Write strobe for the output latch |
| out_wr_data_i | input | NUM_PINS | Data written to the output latch |
| alt_data_i | input | NUM_PINS | Peripheral output data per pin |
| pull_en_i | input | NUM_PINS | Pull resistor enable per pin |
| pull_up_sel_i | input | NUM_PINS | Pull direction: 1 = up, 0 = down |
| pad_in_i | input | NUM_PINS | Raw pad receiver level |
| drv_n_o | output | NUM_PINS | N-side sink enable |
| drv_p_o | output | NUM_PINS | P-side source enable |
| pull_up_o | output | NUM_PINS | Pull-up enable |
| pull_dn_o | output | NUM_PINS | Pull-down enable |
| out_rd_o | output | NUM_PINS | Output latch readback |
| in_rd_o | output | NUM_PINS | Synchronized pad input readback |

## Verification
The hardest case to reach is a pin whose output latch, peripheral data and pad level all disagree while its mode changes. Only in that case is it visible whether the drivers take the right source and whether the two readback paths stay apart. The stimulus first walks all sixteen codes on every pin, using latch and peripheral patterns that are complements of each other. It then switches modes, writes, peripheral data and pad levels at random on every cycle. A behavioural model holds its own latch and a two-deep sample history and is compared on every pin each cycle.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    PM_INPUT  = 4'd0,
    PM_OUT_PP = 4'd1,
    PM_OUT_OD = 4'd2,
    PM_ALT_PP = 4'd3,
    PM_ALT_OD = 4'd4,
    PM_ANALOG = 4'd5
  } pad_mode_e;

  typedef struct packed {
    logic drive_en;
    logic use_alt;
    logic push_pull;
    logic pull_ok;
    logic analog;
  } pad_ctl_t;
endpackage

// File: rtl/gpio_mode_dec.sv
module gpio_mode_dec
  import gpio_pad_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output pad_ctl_t          ctl_o
);
  always_comb begin
    ctl_o = '{drive_en: 1'b0, use_alt: 1'b0, push_pull: 1'b0, pull_ok: 1'b1, analog: 1'b0};
    case (mode_i)
      PM_OUT_PP: begin ctl_o.drive_en = 1'b1; ctl_o.push_pull = 1'b1; end
      PM_OUT_OD: ctl_o.drive_en = 1'b1;
      PM_ALT_PP: begin
        ctl_o.drive_en = 1'b1; ctl_o.push_pull = 1'b1;
        ctl_o.use_alt = 1'b1;  ctl_o.pull_ok = 1'b0;
      end
      PM_ALT_OD: begin
        ctl_o.drive_en = 1'b1; ctl_o.use_alt = 1'b1; ctl_o.pull_ok = 1'b0;
      end
      PM_ANALOG: begin ctl_o.analog = 1'b1; ctl_o.pull_ok = 1'b0; end
      default: ; // input and unused codes
    endcase
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_drv_cell.sv
module gpio_drv_cell
  import gpio_pad_pkg::*;
(
  input  pad_ctl_t ctl_i,
  input  logic     latch_bit_i,
  input  logic     alt_bit_i,
  input  logic     pull_en_i,
  input  logic     pull_up_sel_i,
  output logic     drv_n_o,
  output logic     drv_p_o,
  output logic     pull_up_o,
  output logic     pull_dn_o
);
  logic data;

  assign data      = ctl_i.use_alt ? alt_bit_i : latch_bit_i;
  assign drv_n_o   = ctl_i.drive_en & ~data;
  assign drv_p_o   = ctl_i.drive_en & ctl_i.push_pull & data;
  assign pull_up_o = ctl_i.pull_ok & pull_en_i & pull_up_sel_i;
  assign pull_dn_o = ctl_i.pull_ok & pull_en_i & ~pull_up_sel_i;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PINS*MODE_W-1:0] mode_i,
  input  logic                       out_wr_en_i,
  input  logic [NUM_PINS-1:0]        out_wr_data_i,
  input  logic [NUM_PINS-1:0]        alt_data_i,
  input  logic [NUM_PINS-1:0]        pull_en_i,
  input  logic [NUM_PINS-1:0]        pull_up_sel_i,
  input  logic [NUM_PINS-1:0]        pad_in_i,
  output logic [NUM_PINS-1:0]        drv_n_o,
  output logic [NUM_PINS-1:0]        drv_p_o,
  output logic [NUM_PINS-1:0]        pull_up_o,
  output logic [NUM_PINS-1:0]        pull_dn_o,
  output logic [NUM_PINS-1:0]        out_rd_o,
  output logic [NUM_PINS-1:0]        in_rd_o
);
  logic [NUM_PINS-1:0] out_latch_q;
  logic [NUM_PINS-1:0] pad_sync;
  logic [NUM_PINS-1:0] analog_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          out_latch_q <= '0;
    else if (out_wr_en_i) out_latch_q <= out_wr_data_i;
  end

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pad_sync)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pad_ctl_t ctl;

    gpio_mode_dec u_dec (
      .mode_i(mode_i[i*MODE_W +: MODE_W]),
      .ctl_o (ctl)
    );

    gpio_drv_cell u_cell (
      .ctl_i        (ctl),
      .latch_bit_i  (out_latch_q[i]),
      .alt_bit_i    (alt_data_i[i]),
      .pull_en_i    (pull_en_i[i]),
      .pull_up_sel_i(pull_up_sel_i[i]),
      .drv_n_o      (drv_n_o[i]),
      .drv_p_o      (drv_p_o[i]),
      .pull_up_o    (pull_up_o[i]),
      .pull_dn_o    (pull_dn_o[i])
    );

    assign analog_sel[i] = ctl.analog;
  end

  assign out_rd_o = out_latch_q;
  assign in_rd_o  = pad_sync | analog_sel; // analog pins read as 1
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_PINS*4-1:0] mode_i,
  input logic                  out_wr_en_i,
  input logic [NUM_PINS-1:0]   out_wr_data_i,
  input logic [NUM_PINS-1:0]   alt_data_i,
  input logic [NUM_PINS-1:0]   pad_in_i,
  input logic [NUM_PINS-1:0]   drv_n_o,
  input logic [NUM_PINS-1:0]   drv_p_o,
  input logic [NUM_PINS-1:0]   pull_up_o,
  input logic [NUM_PINS-1:0]   pull_dn_o,
  input logic [NUM_PINS-1:0]   out_rd_o,
  input logic [NUM_PINS-1:0]   in_rd_o
);
  logic [1:0] edges_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             edges_q <= '0;
    else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
  end

  a_r1_out_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_wr_en_i |=> out_rd_o == $past(out_wr_data_i));
  a_r1_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_wr_en_i |=> $stable(out_rd_o));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [3:0] m;
    assign m = mode_i[i*4 +: 4];

    a_r2_od_no_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m == 4'd2 || m == 4'd4) |-> !drv_p_o[i]);
    a_r3_alt_pp_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m == 4'd3 && alt_data_i[i]) |-> (drv_p_o[i] && !drv_n_o[i]));
    a_r5_alt_no_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m == 4'd3 || m == 4'd4) |-> (!pull_up_o[i] && !pull_dn_o[i]));
    a_r6_analog: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m == 4'd5) |-> (in_rd_o[i] && !drv_n_o[i] && !drv_p_o[i]));
    a_r7_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edges_q >= 2'd2 && m != 4'd5) |-> in_rd_o[i] == $past(pad_in_i[i], 2));
    a_r8_input_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m == 4'd0 || m > 4'd5) |-> (!drv_n_o[i] && !drv_p_o[i]));
  end
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .out_wr_en_i  (out_wr_en_i),
  .out_wr_data_i(out_wr_data_i),
  .alt_data_i   (alt_data_i),
  .pad_in_i     (pad_in_i),
  .drv_n_o      (drv_n_o),
  .drv_p_o      (drv_p_o),
  .pull_up_o    (pull_up_o),
  .pull_dn_o    (pull_dn_o),
  .out_rd_o     (out_rd_o),
  .in_rd_o      (in_rd_o)
);

// File: tb/gpio_pad_ctrl_bench.sv
module gpio_pad_ctrl_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic           rst_n;
  logic [N*4-1:0] mode;
  logic           wr_en;
  logic [N-1:0]   wr_data, alt, pen, pup, pad;
  logic [N-1:0]   drv_n, drv_p, pu, pd, out_rd, in_rd;

  gpio_pad_ctrl #(.NUM_PINS(N)) u_gpio_pad_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .out_wr_en_i(wr_en), .out_wr_data_i(wr_data), .alt_data_i(alt),
    .pull_en_i(pen), .pull_up_sel_i(pup), .pad_in_i(pad),
    .drv_n_o(drv_n), .drv_p_o(drv_p), .pull_up_o(pu), .pull_dn_o(pd),
    .out_rd_o(out_rd), .in_rd_o(in_rd)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit mdl_out[N];
  bit hist1[N];
  bit hist2[N];

  task automatic chk(string tag, string what, int pin, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s pin %0d act=%b exp=%b", tag, what, pin, act, exp);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < N; i++) begin
      int  m;
      bit  drive, use_alt, pp, an, d;
      string tg;
      m       = int'(mode[i*4 +: 4]);
      drive   = (m >= 1 && m <= 4);
      use_alt = (m == 3 || m == 4);
      pp      = (m == 1 || m == 3);
      an      = (m == 5);
      d       = use_alt ? alt[i] : mdl_out[i];
      case (m)
        1, 3:    tg = "R3 R4";
        2, 4:    tg = "R2 R4";
        5:       tg = "R6";
        default: tg = "R8";
      endcase
      chk(tg, "drv_n", i, drv_n[i], drive & ~d);
      chk(tg, "drv_p", i, drv_p[i], drive & pp & d);
      chk("R5", "pull_up", i, pu[i], !(use_alt || an) & pen[i] & pup[i]);
      chk("R5", "pull_dn", i, pd[i], !(use_alt || an) & pen[i] & ~pup[i]);
      chk("R1", "out_rd", i, out_rd[i], mdl_out[i]);
      chk(an ? "R6" : "R7", "in_rd", i, in_rd[i], an ? 1'b1 : hist2[i]);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (wr_en) mdl_out[i] = wr_data[i];
      hist2[i] = hist1[i];
      hist1[i] = pad[i];
    end
    #1;
    compare();
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = '0; wr_en = 1'b0; wr_data = '0;
    alt = '0; pen = '0; pup = '0; pad = '0;
    for (int i = 0; i < N; i++) begin mdl_out[i] = 0; hist1[i] = 0; hist2[i] = 0; end
    #9;
    // R9: reset state
    for (int i = 0; i < N; i++) begin
      chk("R9", "out_rd", i, out_rd[i], 1'b0);
      chk("R9", "in_rd", i, in_rd[i], 1'b0);
      chk("R9", "drv_n", i, drv_n[i], 1'b0);
    end
    pad = 8'hFF; // must not leak through while in reset
    #4;
    for (int i = 0; i < N; i++) chk("R9", "in_rd held", i, in_rd[i], 1'b0);
    pad = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // walk every code on all pins, latch and peripheral data complementary
    for (int c = 0; c < 16; c++) begin
      for (int ph = 0; ph < 2; ph++) begin
        for (int i = 0; i < N; i++) mode[i*4 +: 4] = 4'(c);
        wr_en   = 1'b1;
        wr_data = ph ? 8'hA5 : 8'h5A;
        alt     = ~wr_data;
        pen     = 8'hF0;
        pup     = 8'hCC;
        pad     = ph ? 8'h0F : 8'h96;
        cycle();
        wr_en = 1'b0;
        cycle();
        cycle();
      end
    end

    // R1: latch readback unaffected by pad while driving
    for (int i = 0; i < N; i++) mode[i*4 +: 4] = 4'd1;
    wr_en = 1'b1; wr_data = 8'h3C; pad = 8'hC3;
    cycle();
    wr_en = 1'b0;
    repeat (3) cycle();

    // random mixed stimulus
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < N; i++) mode[i*4 +: 4] = 4'($urandom_range(0, 15));
      wr_en   = 1'($urandom_range(0, 1));
      wr_data = 8'($urandom);
      alt     = 8'($urandom);
      pen     = 8'($urandom);
      pup     = 8'($urandom);
      pad     = 8'($urandom);
      cycle();
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule